// File: doc/BRIEF.md
# Rolling-Shutter Pixel Readout Sequencer

This block drives the digital side of a row-by-row readout of a two-dimensional active-pixel array. After a start command it works through the rows in order. For each row it resets the row's pixels and waits out the programmed exposure. It then selects the row, so that every column stage holds that row's levels at the same moment. Finally it steps a column address across the row, so that the held values reach one shared converter one after another.

Two sampling orders are supported. In the correlated order the reset level is captured first and the exposed level second. In the non-correlated order the exposed level is captured first, and the pixel is then reset again while its reset level is captured. An optional calibration step, between the second capture and the column scan, ties the two holding capacitors together so that the offset between the two column outputs can be measured. The array size, exposure length, strobe width, sampling order and calibration switch are latched when a frame starts.

Top module: `pixel_readout_seq`

## Requirements
- R1: After reset, and whenever no frame is running, every strobe, `col_valid`, `busy` and `frame_done` are 0, and `row_addr` and `col_addr` are 0.
- R2: Each row begins with `row_rst` high for `strobe_len` cycles, where 0 counts as 1. Rows are visited 0 to `num_rows`-1 with `row_addr` held for the whole row, and a `num_rows` of 0 counts as 1.
- R3: Between the fall of the first `row_rst` of a row and the rise of `row_sel` there are exactly `int_time` cycles, where 0 counts as 1.
- R4: With `cds_mode`=1, `sh_rst` is high for `strobe_len` cycles and is followed directly by `sh_sig` for `strobe_len` cycles.
- R5: With `cds_mode`=0, `sh_sig` comes first for `strobe_len` cycles and is followed directly by `sh_rst` for `strobe_len` cycles. `row_rst` is high together with that second capture.
- R6: `row_sel` is high exactly during the two sample strobes and never with `col_valid` or `cal_short`.
- R7: With `cal_en`=1, `cal_short` is high for `strobe_len` cycles directly after the second sample strobe. With `cal_en`=0 it never rises.
- R8: The column scan holds `col_valid` high for `num_cols` cycles (0 counts as 1). `col_addr` runs 0, 1, 2 and so on, one step per cycle, and is 0 outside the scan.
- R9: One idle cycle follows each scan. In the idle cycle after the last row, `frame_done` is high for that single cycle, and the block then returns to idle. `busy` is high from the cycle after the accepted start through the `frame_done` cycle.
- R10: A `start` while `busy` is high is ignored. Changes of the configuration inputs during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a frame, taken only when idle |
| num_rows | input | ROW_W | Rows per frame |
| num_cols | input | COL_W | Columns per row |
| int_time | input | TIME_W | Exposure length in clocks |
| strobe_len | input | LEN_W | Width of each strobe in clocks |
| cds_mode | input | 1 | 1: reset level first, 0: exposed level first |
| cal_en | input | 1 | Insert the capacitor-shorting calibration step |
| row_addr | output | ROW_W | Current row |
| row_rst | output | 1 | Row reset strobe |
| row_sel | output | 1 | Row select |
| sh_rst | output | 1 | Reset-level sample strobe |
| sh_sig | output | 1 | Exposed-level sample strobe |
| cal_short | output | 1 | Short both sample capacitors |
| col_addr | output | COL_W | Column routed to the converter |
| col_valid | output | 1 | `col_addr` is being scanned |
| busy | output | 1 | A frame is running |
| frame_done | output | 1 | Last cycle of the frame |

## Verification
All outputs are Moore outputs of one state register. A start driven before a clock edge therefore shows as `row_rst` in the very next cycle, which is offset 0 of the frame. From that point every output has a fixed place in a per-row timeline of length 3·L + T + (cal ? L : 0) + C + 1 cycles. The bench computes each cycle's expected outputs from that offset alone. It samples at the falling edge, half a period after the edge that produced the value. The idle cycles right after `frame_done` are checked in the same way, as are cycles in which a stray start and new configuration values are applied mid-frame.

// File: rtl/pixel_readout_seq.sv
module pixel_readout_seq #(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 10,
  parameter int TIME_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ROW_W-1:0]  num_rows,
  input  logic [COL_W-1:0]  num_cols,
  input  logic [TIME_W-1:0] int_time,
  input  logic [LEN_W-1:0]  strobe_len,
  input  logic              cds_mode,
  input  logic              cal_en,
  output logic [ROW_W-1:0]  row_addr,
  output logic              row_rst,
  output logic              row_sel,
  output logic              sh_rst,
  output logic              sh_sig,
  output logic              cal_short,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_valid,
  output logic              busy,
  output logic              frame_done
);
  localparam int CNT_W = (TIME_W > LEN_W) ? TIME_W : LEN_W;
  localparam logic [ROW_W-1:0] ROW_ONE = 1;
  localparam logic [COL_W-1:0] COL_ONE = 1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  typedef enum logic [2:0] {
    IDLE, ROW_RESET, INTEGRATE, SAMPLE_FIRST, SAMPLE_SECOND, CAL, COL_SCAN, NEXT_ROW
  } state_t;

  state_t state;
  logic [ROW_W-1:0]  row_q, rows_q;
  logic [COL_W-1:0]  col_q, cols_q;
  logic [TIME_W-1:0] time_q;
  logic [LEN_W-1:0]  len_q;
  logic              cds_q, cal_q;
  logic [CNT_W-1:0]  cnt, lim;

  logic [ROW_W-1:0]  eff_rows;
  logic [COL_W-1:0]  eff_cols;
  logic [CNT_W-1:0]  eff_len, eff_time;
  logic              seg_end, last_row, last_col;

  assign eff_rows = (rows_q == '0) ? ROW_ONE : rows_q;
  assign eff_cols = (cols_q == '0) ? COL_ONE : cols_q;
  assign eff_len  = (len_q  == '0) ? CNT_ONE : CNT_W'(len_q);
  assign eff_time = (time_q == '0) ? CNT_ONE : CNT_W'(time_q);
  assign last_row = (row_q == eff_rows - ROW_ONE);
  assign last_col = (col_q == eff_cols - COL_ONE);

  always_comb begin
    case (state)
      INTEGRATE:                              lim = eff_time;
      ROW_RESET, SAMPLE_FIRST, SAMPLE_SECOND,
      CAL:                                    lim = eff_len;
      default:                                lim = CNT_ONE;
    endcase
  end
  assign seg_end = (cnt == lim - CNT_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= IDLE;
      row_q  <= '0;
      col_q  <= '0;
      cnt    <= '0;
      rows_q <= '0;
      cols_q <= '0;
      time_q <= '0;
      len_q  <= '0;
      cds_q  <= 1'b0;
      cal_q  <= 1'b0;
    end else begin
      case (state)
        IDLE: if (start) begin
          rows_q <= num_rows;
          cols_q <= num_cols;
          time_q <= int_time;
          len_q  <= strobe_len;
          cds_q  <= cds_mode;
          cal_q  <= cal_en;
          row_q  <= '0;
          cnt    <= '0;
          state  <= ROW_RESET;
        end
        ROW_RESET, INTEGRATE, SAMPLE_FIRST, SAMPLE_SECOND, CAL:
          if (!seg_end) cnt <= cnt + CNT_ONE;
          else begin
            cnt <= '0;
            case (state)
              ROW_RESET:     state <= INTEGRATE;
              INTEGRATE:     state <= SAMPLE_FIRST;
              SAMPLE_FIRST:  state <= SAMPLE_SECOND;
              SAMPLE_SECOND: state <= cal_q ? CAL : COL_SCAN;
              default:       state <= COL_SCAN;
            endcase
          end
        COL_SCAN:
          if (last_col) begin
            col_q <= '0;
            state <= NEXT_ROW;
          end else col_q <= col_q + COL_ONE;
        default:
          if (last_row) begin
            row_q <= '0;
            state <= IDLE;
          end else begin
            row_q <= row_q + ROW_ONE;
            state <= ROW_RESET;
          end
      endcase
    end
  end

  assign row_addr   = row_q;
  assign row_rst    = (state == ROW_RESET) || (state == SAMPLE_SECOND && !cds_q);
  assign row_sel    = (state == SAMPLE_FIRST) || (state == SAMPLE_SECOND);
  assign sh_rst     = cds_q ? (state == SAMPLE_FIRST) : (state == SAMPLE_SECOND);
  assign sh_sig     = cds_q ? (state == SAMPLE_SECOND) : (state == SAMPLE_FIRST);
  assign cal_short  = (state == CAL);
  assign col_addr   = col_q;
  assign col_valid  = (state == COL_SCAN);
  assign busy       = (state != IDLE);
  assign frame_done = (state == NEXT_ROW) && last_row;

  assert_sel_spans_samples_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_rst || sh_sig) |-> row_sel && !col_valid && !cal_short);
  assert_one_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sh_rst, sh_sig, cal_short, col_valid}));
  assert_col_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && $past(col_valid)) |-> col_addr == $past(col_addr) + COL_ONE);
  assert_col_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid |-> col_addr == '0);
  assert_row_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (row_addr == $past(row_addr) || row_addr == $past(row_addr) + ROW_ONE));
  assert_done_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy && !frame_done);
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !frame_done) |=> busy);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(row_rst || row_sel || sh_rst || sh_sig || cal_short || col_valid) && row_addr == '0);
endmodule

// File: tb/pixel_readout_seq_test.sv
module pixel_readout_seq_test;
  localparam int PERIOD = 10;
  localparam int ROW_W = 8, COL_W = 10, TIME_W = 16, LEN_W = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [ROW_W-1:0]  num_rows = '0;
  logic [COL_W-1:0]  num_cols = '0;
  logic [TIME_W-1:0] int_time = '0;
  logic [LEN_W-1:0]  strobe_len = '0;
  logic cds_mode = 1'b0, cal_en = 1'b0;
  logic [ROW_W-1:0] row_addr;
  logic [COL_W-1:0] col_addr;
  logic row_rst, row_sel, sh_rst, sh_sig, cal_short, col_valid, busy, frame_done;

  int vectors = 0, misses = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  pixel_readout_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .TIME_W(TIME_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_rows(num_rows), .num_cols(num_cols),
    .int_time(int_time), .strobe_len(strobe_len), .cds_mode(cds_mode), .cal_en(cal_en),
    .row_addr(row_addr), .row_rst(row_rst), .row_sel(row_sel), .sh_rst(sh_rst),
    .sh_sig(sh_sig), .cal_short(cal_short), .col_addr(col_addr), .col_valid(col_valid),
    .busy(busy), .frame_done(frame_done));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int nz(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int row_len(input int l, input int t, input int c, input bit cal);
    return 3*nz(l) + nz(t) + (cal ? nz(l) : 0) + nz(c) + 1;
  endfunction

  task automatic model(input int t, input int r_n, input int c_n, input int t_n, input int l_n,
                       input bit cds, input bit cal,
                       output bit rrst, output bit rsel, output bit shr, output bit shs,
                       output bit cs, output bit cv, output int ca, output int ra,
                       output bit bz, output bit dn);
    int L, D, p, r;
    L = nz(l_n);
    D = row_len(l_n, t_n, c_n, cal);
    {rrst, rsel, shr, shs, cs, cv, bz, dn} = '0;
    ca = 0; ra = 0;
    if (t >= 0 && t < nz(r_n) * D) begin
      r = t / D; p = t % D; ra = r; bz = 1;
      if (p < L) rrst = 1;
      else begin
        p -= L;
        if (p >= nz(t_n)) begin
          p -= nz(t_n);
          if (p < L) begin rsel = 1; if (cds) shr = 1; else shs = 1; end
          else begin
            p -= L;
            if (p < L) begin rsel = 1; if (cds) shs = 1; else begin shr = 1; rrst = 1; end end
            else begin
              p -= L;
              if (cal && p < L) cs = 1;
              else begin
                if (cal) p -= L;
                if (p < nz(c_n)) begin cv = 1; ca = p; end
                else dn = (r == nz(r_n) - 1);
              end
            end
          end
        end
      end
    end
  endtask

  task automatic check_cycle(input int t, input int r_n, input int c_n, input int t_n,
                             input int l_n, input bit cds, input bit cal);
    bit rrst, rsel, shr, shs, cs, cv, bz, dn;
    int ca, ra;
    model(t, r_n, c_n, t_n, l_n, cds, cal, rrst, rsel, shr, shs, cs, cv, ca, ra, bz, dn);
    chk("R2", "row_addr", int'(row_addr), ra);
    chk(cds ? "R2" : "R5", "row_rst", int'(row_rst), int'(rrst));
    chk("R3 R6", "row_sel", int'(row_sel), int'(rsel));
    chk(cds ? "R4" : "R5", "sh_rst", int'(sh_rst), int'(shr));
    chk(cds ? "R4" : "R5", "sh_sig", int'(sh_sig), int'(shs));
    chk("R7", "cal_short", int'(cal_short), int'(cs));
    chk("R8", "col_valid", int'(col_valid), int'(cv));
    chk("R8", "col_addr", int'(col_addr), ca);
    chk("R9", "busy", int'(busy), int'(bz));
    chk("R9", "frame_done", int'(frame_done), int'(dn));
  endtask

  // Runs one frame; a stray start plus scrambled configuration lands at cycle inj (R10) if inj >= 0.
  task automatic run_frame(input int r_n, input int c_n, input int t_n, input int l_n,
                           input bit cds, input bit cal, input int inj);
    int total;
    total = nz(r_n) * row_len(l_n, t_n, c_n, cal);
    @(negedge clk);
    num_rows = ROW_W'(r_n); num_cols = COL_W'(c_n); int_time = TIME_W'(t_n);
    strobe_len = LEN_W'(l_n); cds_mode = cds; cal_en = cal; start = 1'b1;
    for (int t = 0; t < total + 2; t++) begin
      @(negedge clk);
      start = 1'b0;
      check_cycle(t, r_n, c_n, t_n, l_n, cds, cal);
      if (t == inj) begin
        start = 1'b1;
        num_rows = ROW_W'(r_n + 3); num_cols = COL_W'(c_n + 2);
        int_time = TIME_W'(t_n + 4); strobe_len = LEN_W'(l_n + 1);
        cds_mode = ~cds; cal_en = ~cal;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check_cycle(-1, 1, 1, 1, 1, 1'b1, 1'b0); // R1 during reset
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_cycle(-1, 1, 1, 1, 1, 1'b1, 1'b0); // R1 after reset, idle

    run_frame(2, 3, 2, 1, 1'b1, 1'b0, -1);   // R4 correlated, plain
    run_frame(2, 3, 2, 2, 1'b0, 1'b0, -1);   // R5 non-correlated
    run_frame(1, 4, 3, 2, 1'b1, 1'b1, -1);   // R7 calibration on
    run_frame(0, 0, 0, 0, 1'b0, 1'b1, -1);   // zero settings count as one
    run_frame(3, 2, 1, 1, 1'b1, 1'b0, 5);    // R10 stray start mid-frame
    run_frame(2, 5, 4, 3, 1'b0, 1'b1, 20);   // R10 during scan area

    for (int k = 0; k < 30; k++) begin
      int r, c, ti, l, inj;
      bit cds, cal;
      r = $urandom_range(4, 1); c = $urandom_range(8, 0); ti = $urandom_range(6, 0);
      l = $urandom_range(3, 0); cds = 1'($urandom); cal = 1'($urandom);
      inj = ($urandom_range(3, 0) == 0) ? int'($urandom_range(15, 0)) : -1;
      run_frame(r, c, ti, l, cds, cal, inj);
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      misses++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule